// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Detector for General-Purpose Input Lines

This block watches a set of general-purpose pins (32 by default) and raises one interrupt line when a selected event appears on any of them. It only observes pin values, so it works whether a pin is an input, a pin driven by this chip, or a pin handed to some other function. Each pin passes through a two-stage synchronizer. The synchronized value is then compared with the value from the previous cycle. A line with its extended mode switched off reports any change of level. A line with the extended mode switched on reports only one kind of event: a rising edge, a falling edge, a high level or a low level.

Software controls the block through a small register port that has an address, a write strobe with data, and a read strobe with combinational read data. Every setting is a per-line bit. Each setting has one write-one-to-set address and one write-one-to-clear address, and a third address reads the current value back. A detected event sets a sticky per-line flag. The interrupt output is the OR, over all lines, of the flag ANDed with the line's enable bit. Reading the flag register returns every pending flag and clears the flags in the same access. A line in level mode sets its flag again on every cycle that its level is present, so the interrupt keeps returning until the pin leaves that level.

Top module: `gpio_evt_irq`

## Requirements
- R1: After reset, every readable register (enable, extended mode, kind, polarity, flags) reads zero and `irq_o` is low.
- R2: Writing address 0x0 sets, and writing address 0x1 clears, every enable bit at a position where `bus_wdata` is 1. Bits where the data is 0 keep their value. Address 0x2 reads the enable bits.
- R3: The same write-one pattern applies to three more pairs. Extended mode is set at 0x3, cleared at 0x4 and read at 0x5. Kind is set to level (1) at 0x6, returned to edge (0) at 0x7 and read at 0x8. Polarity is set to rising/high (1) at 0x9, returned to falling/low (0) at 0xA and read at 0xB.
- R4: A line whose extended mode is 0 sets its flag on both a rising and a falling change. The flag becomes visible after the third rising clock edge that follows the pin change.
- R5: A line with extended mode 1 and kind edge sets its flag only on a rising change when its polarity is 1, and only on a falling change when its polarity is 0.
- R6: A line with extended mode 1 and kind level sets its flag on every cycle that its synchronized pin equals its polarity (1 = high, 0 = low). The flag and the interrupt therefore survive status reads until the level goes away.
- R7: `irq_o` is high exactly when some line has both its flag and its enable bit set. A pending flag whose enable bit is 0 does not raise `irq_o`.
- R8: A read of address 0xC returns all pending flags and clears them. Flags stay set until such a read.
- R9: An event detected in the same cycle as a read of 0xC is not lost. Its flag remains set and is returned by the next read.
- R10: Leaving reset does not report a change, whatever levels the pins hold during and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; sampling and detection need it running |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pin_i | input | NLINES | Observed pin values, asynchronous |
| bus_addr | input | AW | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | NLINES | Write data, one bit per line |
| bus_re | input | 1 | Read strobe; a read of the flag address clears the flags |
| bus_rdata | output | NLINES | Read data, combinational from address while `bus_re` is high |
| irq_o | output | 1 | OR of enabled pending flags |

## Verification
A corrupted setting bit shows in two places. The read-back address of its register pair returns the wrong value at once. The detection path also misbehaves: the wrong edges or levels set flags three edges after the pin moves. A flag register that drops or keeps bits in error shows on the next read of the flag address, and through `irq_o` in the cycle the flag changes. A stale previous-sample value leads to a false flag right after reset or a missing flag after a pin change. The checks therefore sample flags three clock edges after each pin stimulus and read the flags twice across every clearing read.

// File: rtl/gpio_evt_pkg.sv
`timescale 1ns/1ps
package gpio_evt_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_EN_SET   = 4'h0;
  localparam logic [ADDR_W-1:0] A_EN_CLR   = 4'h1;
  localparam logic [ADDR_W-1:0] A_EN_RD    = 4'h2;
  localparam logic [ADDR_W-1:0] A_XM_SET   = 4'h3;
  localparam logic [ADDR_W-1:0] A_XM_CLR   = 4'h4;
  localparam logic [ADDR_W-1:0] A_XM_RD    = 4'h5;
  localparam logic [ADDR_W-1:0] A_LVL_SET  = 4'h6;
  localparam logic [ADDR_W-1:0] A_EDGE_SET = 4'h7;
  localparam logic [ADDR_W-1:0] A_KIND_RD  = 4'h8;
  localparam logic [ADDR_W-1:0] A_HI_SET   = 4'h9;
  localparam logic [ADDR_W-1:0] A_LO_SET   = 4'hA;
  localparam logic [ADDR_W-1:0] A_POL_RD   = 4'hB;
  localparam logic [ADDR_W-1:0] A_FLAGS_RD = 4'hC;

  // Per-line configuration seen by the detector
  typedef struct packed {
    logic xmode;  // 1: polarity-specific event
    logic level;  // 1: level, 0: edge
    logic high;   // 1: rising/high, 0: falling/low
  } line_cfg_t;
endpackage

// File: rtl/gpio_evt_setclr.sv
`timescale 1ns/1ps
module gpio_evt_setclr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;
  logic         upd;

  always_comb begin
    upd = set_en | clr_en;
    q_n = q;
    if (set_en) q_n = q_n | wdata;
    if (clr_en) q_n = q_n & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= q_n;
  end
endmodule

// File: rtl/gpio_evt_sync.sv
`timescale 1ns/1ps
module gpio_evt_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o,
  output logic         ready_o
);
  localparam int VDEPTH = STAGES + 1;

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;
  logic [VDEPTH-1:0] vld_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else if (s == 0) stg_q[s] <= pin_i;
        else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  // Validity pipeline: prev holds a real sample once the top bit is set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      prev_q <= '0;
    end else begin
      vld_q  <= {vld_q[VDEPTH-2:0], 1'b1};
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign cur_o   = stg_q[STAGES-1];
  assign prev_o  = prev_q;
  assign ready_o = vld_q[VDEPTH-1];
endmodule

// File: rtl/gpio_evt_detect.sv
`timescale 1ns/1ps
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         ready_i,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  line_cfg_t    cfg_i [W],
  output logic [W-1:0] evt_o
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_line
      logic rise, fall, hit;
      always_comb begin
        rise = cur_i[i] & ~prev_i[i];
        fall = ~cur_i[i] & prev_i[i];
        if (!cfg_i[i].xmode)     hit = rise | fall;
        else if (cfg_i[i].level) hit = (cur_i[i] == cfg_i[i].high);
        else                     hit = cfg_i[i].high ? rise : fall;
        evt_o[i] = ready_i & hit;
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_evt_irq.sv
`timescale 1ns/1ps
module gpio_evt_irq
  import gpio_evt_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int AW     = ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] pin_i,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [NLINES-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [NLINES-1:0] bus_rdata,
  output logic              irq_o
);
  logic [NLINES-1:0] en_q, xm_q, kind_q, pol_q;
  logic [NLINES-1:0] cur, prev, evt;
  logic [NLINES-1:0] flags_q, flags_n;
  logic              ready, rd_flags;
  line_cfg_t         cfg [NLINES];

  function automatic logic hit(input logic [AW-1:0] a);
    return bus_we && (bus_addr == a);
  endfunction

  gpio_evt_setclr #(.W(NLINES)) u_en (
    .clk(clk), .rst_n(rst_n), .set_en(hit(A_EN_SET)), .clr_en(hit(A_EN_CLR)),
    .wdata(bus_wdata), .q(en_q));
  gpio_evt_setclr #(.W(NLINES)) u_xm (
    .clk(clk), .rst_n(rst_n), .set_en(hit(A_XM_SET)), .clr_en(hit(A_XM_CLR)),
    .wdata(bus_wdata), .q(xm_q));
  gpio_evt_setclr #(.W(NLINES)) u_kind (
    .clk(clk), .rst_n(rst_n), .set_en(hit(A_LVL_SET)), .clr_en(hit(A_EDGE_SET)),
    .wdata(bus_wdata), .q(kind_q));
  gpio_evt_setclr #(.W(NLINES)) u_pol (
    .clk(clk), .rst_n(rst_n), .set_en(hit(A_HI_SET)), .clr_en(hit(A_LO_SET)),
    .wdata(bus_wdata), .q(pol_q));

  gpio_evt_sync #(.W(NLINES), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .cur_o(cur), .prev_o(prev), .ready_o(ready));

  genvar i;
  generate
    for (i = 0; i < NLINES; i++) begin : g_cfg
      assign cfg[i] = '{xmode: xm_q[i], level: kind_q[i], high: pol_q[i]};
    end
  endgenerate

  gpio_evt_detect #(.W(NLINES)) u_det (
    .ready_i(ready), .cur_i(cur), .prev_i(prev), .cfg_i(cfg), .evt_o(evt));

  // Flags: clear-on-read, new events win over the clear
  always_comb begin
    rd_flags = bus_re && (bus_addr == A_FLAGS_RD);
    flags_n  = (rd_flags ? '0 : flags_q) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_n;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (bus_addr)
        A_EN_RD:    bus_rdata = en_q;
        A_XM_RD:    bus_rdata = xm_q;
        A_KIND_RD:  bus_rdata = kind_q;
        A_POL_RD:   bus_rdata = pol_q;
        A_FLAGS_RD: bus_rdata = flags_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign irq_o = |(flags_q & en_q);
endmodule

module gpio_evt_irq_chk
  import gpio_evt_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int AW     = ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     bus_addr,
  input logic              bus_we,
  input logic [NLINES-1:0] bus_wdata,
  input logic              rd_flags,
  input logic              ready,
  input logic [NLINES-1:0] evt,
  input logic [NLINES-1:0] flags_q,
  input logic [NLINES-1:0] en_q
);
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_EN_SET) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata))); // R2
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_EN_CLR) |=> ((en_q & $past(bus_wdata)) == '0)); // R2
  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flags_q & $past(evt)) == $past(evt))); // R9
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flags |=> ((flags_q & ~$past(evt)) == '0)); // R8
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_flags |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R8
  AST_NO_EARLY_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (evt == '0)); // R10
endmodule

bind gpio_evt_irq gpio_evt_irq_chk #(.NLINES(NLINES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .rd_flags(rd_flags), .ready(ready), .evt(evt),
  .flags_q(flags_q), .en_q(en_q));

// File: tb/gpio_evt_irq_bench.sv
`timescale 1ns/1ps
module gpio_evt_irq_bench;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pin = '0;
  logic [3:0]    addr = '0;
  logic          we = 1'b0;
  logic [N-1:0]  wdata = '0;
  logic          re = 1'b0;
  logic [N-1:0]  rdata;
  logic          irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_evt_irq u_gpio_evt_irq (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_re(re), .bus_rdata(rdata), .irq_o(irq));

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
    addr = a; re = 1'b1;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    re = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [N-1:0] pins);
    pin = pins;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic flush();
    logic [N-1:0] d;
    settle();
    rd(4'hC, d);
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    do_reset('0);
    rd(4'h2, d); chk("R1 enable", d, '0);
    rd(4'h5, d); chk("R1 xmode", d, '0);
    rd(4'h8, d); chk("R1 kind", d, '0);
    rd(4'hB, d); chk("R1 polarity", d, '0);
    rd(4'hC, d); chk("R1 flags", d, '0);
    chk("R1 irq", {31'd0, irq}, '0);
  endtask

  task automatic t_setclr();
    logic [N-1:0] d;
    wr(4'h0, 32'h0000_F0F0);
    wr(4'h0, 32'h0300_0000);
    rd(4'h2, d); chk("R2 enable set", d, 32'h0300_F0F0);
    wr(4'h1, 32'h0100_00F0);
    rd(4'h2, d); chk("R2 enable clear", d, 32'h0200_F000);
    wr(4'h1, 32'hFFFF_FFFF);
    rd(4'h2, d); chk("R2 enable clear all", d, '0);
    wr(4'h3, 32'h0000_00FF); wr(4'h4, 32'h0000_0003);
    rd(4'h5, d); chk("R3 xmode pair", d, 32'h0000_00FC);
    wr(4'h6, 32'h0000_0038); wr(4'h7, 32'h0000_0008);
    rd(4'h8, d); chk("R3 kind pair", d, 32'h0000_0030);
    wr(4'h9, 32'h0000_00B5); wr(4'hA, 32'h0000_0004);
    rd(4'hB, d); chk("R3 polarity pair", d, 32'h0000_00B1);
    wr(4'h4, 32'hFFFF_FFFF); wr(4'h7, 32'hFFFF_FFFF); wr(4'hA, 32'hFFFF_FFFF);
    rd(4'h5, d); chk("R3 xmode cleared", d, '0);
  endtask

  task automatic t_any_edge();
    logic [N-1:0] d;
    flush();
    pin[20] = 1'b1;
    repeat (2) @(posedge clk); #1;
    rd(4'hC, d); chk("R4 not before third edge", d, '0);
    flush();
    pin[20] = 1'b1; pin[21] = 1'b1;
    settle();
    rd(4'hC, d); chk("R4 rising change", d, 32'h0020_0000);
    pin[20] = 1'b0; pin[21] = 1'b0;
    settle();
    rd(4'hC, d); chk("R4 falling change", d, 32'h0030_0000);
  endtask

  task automatic t_polar_edge();
    logic [N-1:0] d;
    wr(4'h3, 32'h0000_0003);
    wr(4'h9, 32'h0000_0001);
    flush();
    pin[1:0] = 2'b11;
    settle();
    rd(4'hC, d); chk("R5 rising only on line 0", d, 32'h0000_0001);
    pin[1:0] = 2'b00;
    settle();
    rd(4'hC, d); chk("R5 falling only on line 1", d, 32'h0000_0002);
    wr(4'h4, 32'h0000_0003); wr(4'hA, 32'h0000_0001);
  endtask

  task automatic t_level();
    logic [N-1:0] d;
    pin[4] = 1'b1; pin[3] = 1'b1;
    flush();
    wr(4'h3, 32'h0000_0018);
    wr(4'h6, 32'h0000_0018);
    wr(4'h9, 32'h0000_0010);
    wr(4'h0, 32'h0000_0018);
    settle();
    rd(4'hC, d); chk("R6 high level line 4", d, 32'h0000_0010);
    rd(4'hC, d); chk("R6 high level again after read", d, 32'h0000_0010);
    chk("R6 irq held", {31'd0, irq}, 32'd1);
    pin[3] = 1'b0; pin[4] = 1'b0;
    settle();
    rd(4'hC, d);
    rd(4'hC, d); chk("R6 low level line 3 only", d, 32'h0000_0008);
    pin[3] = 1'b1;
    settle();
    rd(4'hC, d);
    rd(4'hC, d); chk("R6 level gone", d, '0);
    chk("R6 irq released", {31'd0, irq}, '0);
    wr(4'h1, 32'hFFFF_FFFF); wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h7, 32'hFFFF_FFFF); wr(4'hA, 32'hFFFF_FFFF);
    flush();
  endtask

  task automatic t_mask();
    logic [N-1:0] d;
    flush();
    pin[9] = 1'b1;
    settle();
    chk("R7 unmasked flag no irq", {31'd0, irq}, '0);
    wr(4'h0, 32'h0000_0200);
    chk("R7 irq on enable", {31'd0, irq}, 32'd1);
    wr(4'h1, 32'h0000_0100);
    chk("R7 other clear keeps irq", {31'd0, irq}, 32'd1);
    wr(4'h1, 32'h0000_0200);
    chk("R7 irq off on disable", {31'd0, irq}, '0);
    wr(4'h0, 32'h0000_0200);
    rd(4'hC, d); chk("R8 read returns pending", d, 32'h0000_0200);
    chk("R8 irq after clear", {31'd0, irq}, '0);
    rd(4'hC, d); chk("R8 cleared by read", d, '0);
    wr(4'h1, 32'hFFFF_FFFF);
  endtask

  task automatic t_collision();
    logic [N-1:0] d;
    flush();
    pin[12] = 1'b1;
    settle();
    pin[13] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    rd(4'hC, d); chk("R9 first read old flag", d, 32'h0000_1000);
    rd(4'hC, d); chk("R9 same-cycle event kept", d, 32'h0000_2000);
    rd(4'hC, d); chk("R9 then clear", d, '0);
  endtask

  task automatic t_no_false();
    logic [N-1:0] d;
    do_reset(32'hFFFF_FFFF);
    rd(4'hC, d); chk("R10 no change after reset, pins high", d, '0);
    do_reset(32'h5A5A_A5A5);
    rd(4'hC, d); chk("R10 no change after reset, mixed pins", d, '0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_setclr();
    t_any_edge();
    t_polar_edge();
    t_level();
    t_mask();
    t_collision();
    t_no_false();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule